// File: doc/BRIEF.md
# Burst Byte-Copy Channel with Grouped Source Rewind

This block is one channel of a direct memory access engine. It moves bytes from a peripheral's data window into memory, one read cycle followed by one write cycle per byte, and holds a shared bus for the whole burst. Software programs four values through a small write port: a source start address, a destination address, a byte count and a control word. A peripheral then raises a request line to start the transfer.

The control word can enable rewind mode. In rewind mode the channel copies four bytes and then stops. The source address goes back to its programmed start. The destination address and the count keep their advanced values. The channel then releases the bus and clears the peripheral's request flag, and it waits for a fresh request before it copies the next group. Without rewind mode, the channel copies bytes back to back until the count reaches zero. When the count reaches zero the channel marks the transfer as done, turns itself off and clears the request flag in either mode. An interrupt is raised only at that point, and only if it is enabled.

Top module: `dma_reload_chan`

## Requirements
- R1: Each byte takes two clock cycles. In the first, memRd is high and memAddr is the current source address. In the next, memWr is high, memAddr is the destination address and memWdata carries the byte read in the previous cycle. After the write, the destination address and the count have moved on by one. The source address has also moved on by one, except at a rewind.
- R2: When rewind mode is on, the write that completes a group of four bytes returns the source address to its programmed start value. The group position restarts when the source or count register is written.
- R3: The destination address advances by one after every byte, in both modes, and keeps counting across group boundaries.
- R4: The count drops by one after every byte in both modes. For example, 8 becomes 4 after one group.
- R5: busReq rises in the cycle after an accepted request. It stays high until the last write of the group (rewind mode) or the last write of the count (normal mode), and it is low in the cycle after that write. The read cycle starts only in the cycle after busGnt is seen high. In normal mode, each write is followed directly by the next read.
- R6: reqClr is high for exactly the write cycle that ends a rewind group and for the write cycle of the final byte, in both modes. At no other time is it high.
- R7: When the count reaches zero, xferDone is set and chanEn is cleared. irq equals xferDone AND the interrupt-enable bit, so no interrupt is raised at a group boundary.
- R8: After a rewind halt, the channel makes no bus request until the peripheral raises xferReq again.
- R9: A request is refused when rewind mode is on and count[1:0] is not 0, or when the count is 0. A refused request sets cfgErr and never raises busReq. A control write clears cfgErr and xferDone.
- R10: While chanEn is low, xferReq is ignored: busReq stays low and the registers do not change.
- R11: Register select cfgSel: 0 = source start (this also loads the current source), 1 = destination, 2 = count, 3 = control. Control bit 0 = enable, bit 1 = rewind mode, bit 2 = interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Register write strobe |
| cfgSel | input | 2 | Register select |
| cfgWdata | input | AW | Register write data |
| xferReq | input | 1 | Peripheral transfer request (level) |
| reqClr | output | 1 | Pulse that clears the peripheral request flag |
| busReq | output | 1 | Bus request |
| busGnt | input | 1 | Bus grant |
| memAddr | output | AW | Memory address |
| memRd | output | 1 | Read cycle |
| memWr | output | 1 | Write cycle |
| memWdata | output | DW | Write data |
| memRdata | input | DW | Read data, valid in the read cycle |
| srcAddr | output | AW | Current source address |
| dstAddr | output | AW | Current destination address |
| xferCount | output | CW | Remaining byte count |
| chanEn | output | 1 | Channel enable |
| xferDone | output | 1 | Transfer-end flag |
| cfgErr | output | 1 | Refused-start flag |
| irq | output | 1 | Completion interrupt |

## Verification
Every result is registered, so each change appears one clock edge after its cause. busReq rises one edge after a request is accepted, and the read cycle begins one edge after grant is seen. The address, count and flag updates land on the edge that closes the write cycle. reqClr is valid throughout that write cycle itself. The bench drives its inputs and grant on falling edges and moves its reference model on rising edges. It compares all outputs on the next falling edge, so each expectation is checked in the cycle it is due. Scenario checks with fixed expected values then confirm the state at each halt.

// File: rtl/dma_reload_pkg.sv
package dma_reload_pkg;
  // register select codes
  localparam logic [1:0] SEL_SRC = 2'd0;
  localparam logic [1:0] SEL_DST = 2'd1;
  localparam logic [1:0] SEL_CNT = 2'd2;
  localparam logic [1:0] SEL_CTL = 2'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic rdPhase;   // memAddr selects source
    logic latch;     // capture read byte
    logic advance;   // step addresses and count
    logic finish;    // set done, clear enable
    logic setErr;    // refused start
  } ctlStrb_t;

  // status from datapath to control
  typedef struct packed {
    logic en;
    logic rewind;
    logic grpLast;
    logic cntOne;
    logic startBad;
  } dpStat_t;
endpackage

// File: rtl/dma_reload_dp.sv
module dma_reload_dp
  import dma_reload_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 8,
  parameter int CW = 16,
  parameter int GRP_LOG2 = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWe,
  input  logic [1:0]    cfgSel,
  input  logic [AW-1:0] cfgWdata,
  input  ctlStrb_t      strb,
  output dpStat_t       stat,
  input  logic [DW-1:0] memRdata,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  output logic [AW-1:0] srcAddr,
  output logic [AW-1:0] dstAddr,
  output logic [CW-1:0] xferCount,
  output logic          chanEn,
  output logic          xferDone,
  output logic          cfgErr,
  output logic          irq
);
  localparam int GW = GRP_LOG2;
  localparam logic [GW-1:0] GRP_MAX = '1;

  logic [AW-1:0] srcStart, srcQ, dstQ;
  logic [CW-1:0] cntQ;
  logic [GW-1:0] grpQ;
  logic [DW-1:0] byteQ;
  logic enQ, rewQ, ieQ, doneQ, errQ;
  logic rewindNow;

  assign rewindNow = rewQ && (grpQ == GRP_MAX);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcStart <= '0; srcQ <= '0; dstQ <= '0; cntQ <= '0; grpQ <= '0;
      byteQ <= '0; enQ <= 1'b0; rewQ <= 1'b0; ieQ <= 1'b0;
      doneQ <= 1'b0; errQ <= 1'b0;
    end else begin
      if (strb.latch) byteQ <= memRdata;
      if (strb.advance) begin
        srcQ <= rewindNow ? srcStart : srcQ + 1'b1;
        dstQ <= dstQ + 1'b1;
        cntQ <= cntQ - 1'b1;
        grpQ <= grpQ + 1'b1;
      end
      if (strb.finish) begin
        doneQ <= 1'b1;
        enQ   <= 1'b0;
      end
      if (strb.setErr) errQ <= 1'b1;
      if (cfgWe) begin
        unique case (cfgSel)
          SEL_SRC: begin srcStart <= cfgWdata; srcQ <= cfgWdata; grpQ <= '0; end
          SEL_DST: dstQ <= cfgWdata;
          SEL_CNT: begin cntQ <= cfgWdata[CW-1:0]; grpQ <= '0; end
          default: begin
            enQ <= cfgWdata[0]; rewQ <= cfgWdata[1]; ieQ <= cfgWdata[2];
            doneQ <= 1'b0; errQ <= 1'b0;
          end
        endcase
      end
    end
  end

  always_comb begin
    stat.en       = enQ;
    stat.rewind   = rewQ;
    stat.grpLast  = (grpQ == GRP_MAX);
    stat.cntOne   = (cntQ == CW'(1));
    stat.startBad = (cntQ == '0) || (rewQ && (cntQ[GW-1:0] != '0));
  end

  assign memAddr   = strb.rdPhase ? srcQ : dstQ;
  assign memWdata  = byteQ;
  assign srcAddr   = srcQ;
  assign dstAddr   = dstQ;
  assign xferCount = cntQ;
  assign chanEn    = enQ;
  assign xferDone  = doneQ;
  assign cfgErr    = errQ;
  assign irq       = doneQ && ieQ;

  p_src_reload_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && rewQ && grpQ == GRP_MAX && !cfgWe) |=> (srcQ == srcStart));
  p_dst_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && !cfgWe) |=> (dstQ == $past(dstQ) + 1'b1));
  p_cnt_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && !cfgWe) |=> (cntQ == $past(cntQ) - 1'b1));
  p_done_at_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneQ) |-> (cntQ == '0 && !enQ));
endmodule

// File: rtl/dma_reload_ctrl.sv
module dma_reload_ctrl
  import dma_reload_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     xferReq,
  input  logic     busGnt,
  input  dpStat_t  stat,
  output ctlStrb_t strb,
  output logic     busReq,
  output logic     memRd,
  output logic     memWr,
  output logic     reqClr
);
  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_READ, S_WRITE} state_t;
  state_t stateQ, stateD;
  logic groupEnd, lastByte;

  assign groupEnd = stat.rewind && stat.grpLast;
  assign lastByte = stat.cntOne;

  always_comb begin
    stateD = stateQ;
    strb   = '0;
    unique case (stateQ)
      S_IDLE: if (stat.en && xferReq) begin
        if (stat.startBad) strb.setErr = 1'b1;
        else               stateD = S_WAIT;
      end
      S_WAIT: if (busGnt) stateD = S_READ;
      S_READ: begin
        strb.rdPhase = 1'b1;
        strb.latch   = 1'b1;
        stateD       = S_WRITE;
      end
      default: begin
        strb.advance = 1'b1;
        strb.finish  = lastByte;
        stateD       = (groupEnd || lastByte) ? S_IDLE : S_READ;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= S_IDLE;
    else       stateQ <= stateD;
  end

  assign busReq = (stateQ != S_IDLE);
  assign memRd  = (stateQ == S_READ);
  assign memWr  = (stateQ == S_WRITE);
  assign reqClr = memWr && (groupEnd || lastByte);

  p_wr_follows_rd_r1: assert property (@(posedge clk) disable iff (!rstN)
    memRd |=> memWr);
  p_burst_holds_r5: assert property (@(posedge clk) disable iff (!rstN)
    (memWr && !reqClr) |=> (memRd && busReq));
  p_release_r5: assert property (@(posedge clk) disable iff (!rstN)
    reqClr |=> !busReq);
  p_off_ignored_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!busReq && !stat.en) |=> !busReq);
endmodule

// File: rtl/dma_reload_chan.sv
module dma_reload_chan
  import dma_reload_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 8,
  parameter int CW = 16,
  parameter int GRP_LOG2 = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWe,
  input  logic [1:0]    cfgSel,
  input  logic [AW-1:0] cfgWdata,
  input  logic          xferReq,
  output logic          reqClr,
  output logic          busReq,
  input  logic          busGnt,
  output logic [AW-1:0] memAddr,
  output logic          memRd,
  output logic          memWr,
  output logic [DW-1:0] memWdata,
  input  logic [DW-1:0] memRdata,
  output logic [AW-1:0] srcAddr,
  output logic [AW-1:0] dstAddr,
  output logic [CW-1:0] xferCount,
  output logic          chanEn,
  output logic          xferDone,
  output logic          cfgErr,
  output logic          irq
);
  ctlStrb_t strb;
  dpStat_t  stat;

  dma_reload_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .xferReq(xferReq), .busGnt(busGnt),
    .stat(stat), .strb(strb), .busReq(busReq), .memRd(memRd),
    .memWr(memWr), .reqClr(reqClr)
  );

  dma_reload_dp #(.AW(AW), .DW(DW), .CW(CW), .GRP_LOG2(GRP_LOG2)) u_dp (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgWdata(cfgWdata),
    .strb(strb), .stat(stat), .memRdata(memRdata), .memAddr(memAddr),
    .memWdata(memWdata), .srcAddr(srcAddr), .dstAddr(dstAddr),
    .xferCount(xferCount), .chanEn(chanEn), .xferDone(xferDone),
    .cfgErr(cfgErr), .irq(irq)
  );
endmodule

// File: tb/dma_reload_chan_test.sv
module dma_reload_chan_test;
  logic clk = 0, rstN = 0;
  logic cfgWe = 0; logic [1:0] cfgSel = 0; logic [31:0] cfgWdata = 0;
  logic xferReq = 0, busGnt = 0, gntOn = 1;
  logic reqClr, busReq, memRd, memWr, chanEn, xferDone, cfgErr, irq;
  logic [31:0] memAddr, srcAddr, dstAddr;
  logic [7:0] memWdata, memRdata;
  logic [15:0] xferCount;
  logic [7:0] mem [256];
  int nTests = 0, nFail = 0, cyc = 0;
  bit cmpOn = 0;

  // reference model state
  int mPhase, mSrc, mStart, mDst, mCnt, mGrp;
  bit mEn, mRel, mIe, mDone, mErr;
  logic [7:0] mByte;

  always #10 clk = ~clk;

  dma_reload_chan uut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgWdata(cfgWdata),
    .xferReq(xferReq), .reqClr(reqClr), .busReq(busReq), .busGnt(busGnt),
    .memAddr(memAddr), .memRd(memRd), .memWr(memWr), .memWdata(memWdata),
    .memRdata(memRdata), .srcAddr(srcAddr), .dstAddr(dstAddr),
    .xferCount(xferCount), .chanEn(chanEn), .xferDone(xferDone),
    .cfgErr(cfgErr), .irq(irq)
  );

  assign memRdata = mem[memAddr[7:0]];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory, grant and peripheral flag act on falling edges
  always @(negedge clk) begin
    if (memWr) mem[memAddr[7:0]] <= memWdata;
    busGnt <= busReq && gntOn;
    if (reqClr) xferReq <= 1'b0;
  end

  // reference model moves on rising edges
  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; mSrc = 0; mStart = 0; mDst = 0; mCnt = 0; mGrp = 0;
      mEn = 0; mRel = 0; mIe = 0; mDone = 0; mErr = 0; mByte = 0;
    end else begin
      case (mPhase)
        0: if (mEn && xferReq) begin
             if (mCnt == 0 || (mRel && (mCnt % 4) != 0)) mErr = 1;
             else mPhase = 1;
           end
        1: if (busGnt) mPhase = 2;
        2: begin mByte = mem[mSrc & 255]; mPhase = 3; end
        default: begin
          bit fin, ge;
          fin = (mCnt == 1);
          ge  = mRel && (mGrp == 3);
          mSrc = ge ? mStart : mSrc + 1;
          mDst = mDst + 1; mCnt = mCnt - 1; mGrp = (mGrp + 1) % 4;
          if (fin) begin mDone = 1; mEn = 0; end
          mPhase = (fin || ge) ? 0 : 2;
        end
      endcase
      if (cfgWe) case (cfgSel)
        2'd0: begin mStart = cfgWdata; mSrc = cfgWdata; mGrp = 0; end
        2'd1: mDst = cfgWdata;
        2'd2: begin mCnt = cfgWdata[15:0]; mGrp = 0; end
        default: begin
          mEn = cfgWdata[0]; mRel = cfgWdata[1]; mIe = cfgWdata[2];
          mDone = 0; mErr = 0;
        end
      endcase
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) if (cmpOn) begin
    chk("R5 busReq", busReq, mPhase != 0);
    chk("R1 memRd", memRd, mPhase == 2);
    chk("R1 memWr", memWr, mPhase == 3);
    if (mPhase == 2) chk("R1 read addr", memAddr, mSrc);
    if (mPhase == 3) begin
      chk("R1 write addr", memAddr, mDst);
      chk("R1 write data", memWdata, mByte);
    end
    chk("R6 reqClr", reqClr, mPhase == 3 && (mCnt == 1 || (mRel && mGrp == 3)));
    chk("R2 srcAddr", srcAddr, mSrc);
    chk("R3 dstAddr", dstAddr, mDst);
    chk("R4 xferCount", xferCount, mCnt);
    chk("R7 chanEn", chanEn, mEn);
    chk("R7 xferDone", xferDone, mDone);
    chk("R7 irq", irq, mDone && mIe);
    chk("R9 cfgErr", cfgErr, mErr);
  end

  task automatic cfgWrite(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk); cfgWe = 1; cfgSel = sel; cfgWdata = d;
    @(negedge clk); cfgWe = 0;
  endtask

  task automatic raise();
    @(negedge clk); xferReq = 1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R7 reset busReq", busReq, 0);
    chk("R7 reset chanEn", chanEn, 0);
    chk("R7 reset irq", irq, 0);
    cmpOn = 1;

    // R10: requests ignored while disabled
    cfgWrite(2'd0, 32'h20); cfgWrite(2'd1, 32'h60); cfgWrite(2'd2, 32'd8);
    raise(); idle(6);
    chk("R10 no bus while off", busReq, 0);
    chk("R10 count untouched", xferCount, 8);
    @(negedge clk); xferReq = 0;

    // R2/R3/R4/R6/R8: rewind mode, two groups
    cfgWrite(2'd3, 32'h7);
    raise(); idle(20);
    chk("R2 src rewound", srcAddr, 32'h20);
    chk("R3 dst advanced", dstAddr, 32'h64);
    chk("R4 count after group", xferCount, 4);
    chk("R6 flag cleared", xferReq, 0);
    chk("R7 no irq at group end", irq, 0);
    chk("R11 copied byte", mem[8'h63], 8'h23 ^ 8'h5A);
    idle(10);
    chk("R8 halted without request", busReq, 0);
    raise(); idle(20);
    chk("R4 count zero", xferCount, 0);
    chk("R3 dst second group", dstAddr, 32'h68);
    chk("R7 done", xferDone, 1);
    chk("R7 irq", irq, 1);
    chk("R7 enable cleared", chanEn, 0);

    // R5: normal mode with grant stalled, then long burst
    cfgWrite(2'd0, 32'h20); cfgWrite(2'd1, 32'h80); cfgWrite(2'd2, 32'd6);
    cfgWrite(2'd3, 32'h1);
    gntOn = 0;
    raise(); idle(5);
    chk("R5 waits for grant", memRd, 0);
    chk("R5 request held", busReq, 1);
    gntOn = 1; idle(20);
    chk("R1 src continues", srcAddr, 32'h26);
    chk("R4 count zero normal", xferCount, 0);
    chk("R7 no irq when disabled", irq, 0);
    chk("R7 done normal", xferDone, 1);
    chk("R6 flag cleared normal", xferReq, 0);

    // R9: misaligned count with rewind refused
    cfgWrite(2'd2, 32'd6); cfgWrite(2'd3, 32'h3);
    raise(); idle(4);
    chk("R9 error set", cfgErr, 1);
    chk("R9 no bus", busReq, 0);
    @(negedge clk); xferReq = 0;
    cfgWrite(2'd3, 32'h0);
    chk("R9 error cleared", cfgErr, 0);
    cfgWrite(2'd2, 32'd0); cfgWrite(2'd3, 32'h1);
    raise(); idle(4);
    chk("R9 zero count refused", cfgErr, 1);
    @(negedge clk); xferReq = 0;
    idle(2);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      nTests++; nFail++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule